// File: doc/BRIEF.md
# Per-Task Microcode Store Selector

This block holds one store-select bit for each of sixteen prioritized microcode tasks. A bit value of 1 means the task fetches its microinstructions from the fixed ROM, and 0 means it fetches them from the writable RAM. The address generator reads the bit of the task that is running. A selection tells it which store to address. Task 0 has the lowest priority and is the emulator. Task 15 has the highest priority.

A second 16-bit register holds the boot pattern. A function can load it from the processor bus, but only when a RAM-capable task executes that function. During a reset operation, every task's select bit is copied from this pattern, and the pattern then returns to all ones. A swap function flips the emulator's bit, again only when a RAM-capable task issues it. The flip is held back for one microinstruction, so the microinstruction right after the swap still fetches from the old store. Function strobes count only in a cycle where the microinstruction-complete strobe is high.

Top module: `task_mode_ctl`

## Requirements
- R1: `cur_rom` shows the select bit of the task on `task_id` in the same cycle, with no clock edge needed. A value of 1 means ROM and 0 means RAM.
- R2: While `rst_n` is low, every select bit is 1, the boot pattern is all ones, and no swap is waiting.
- R3: The boot pattern is loaded from `bus` at a clock edge where `uinst_done`, `fn_load_boot` and `task_is_ram` are all high. Bus bit i belongs to task i, so bit 0 is the emulator and bit 15 is the top-priority task.
- R4: At a clock edge where `reset_op` is high, every task's select bit takes the value of its bit in the boot pattern.
- R5: At the same edge as a reset operation, the boot pattern returns to all ones. A second reset operation with no load in between therefore puts every task on ROM.
- R6: A swap issued at completion strobe k, with `fn_swap`, `task_is_ram` and `uinst_done` all high, inverts the emulator's select bit at the next completion strobe. The bit does not change at strobe k, and it does not change in idle cycles between the two strobes.
- R7: A swap or a boot-pattern load issued while `task_is_ram` is low has no effect.
- R8: A swap or a load strobe in a cycle where `uinst_done` is low has no effect.
- R9: A swap never changes the select bit of any task other than the emulator.
- R10: Swaps issued at two consecutive completion strobes invert the emulator's bit twice, once at each of the two following strobes. A reset operation drops a swap that is still waiting.
- R11: A reset operation takes precedence over a boot-pattern load in the same cycle. The select bits take the old pattern, and the pattern becomes all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_id | input | 4 | Number of the task that is running |
| task_is_ram | input | 1 | The running task is RAM-capable |
| fn_load_boot | input | 1 | Decoded function: load the boot pattern from the bus |
| fn_swap | input | 1 | Decoded function: swap the emulator's store |
| uinst_done | input | 1 | The current microinstruction completes in this cycle |
| reset_op | input | 1 | Reset operation: copy the boot pattern into the select bits |
| bus | input | 16 | Processor bus |
| cur_rom | output | 1 | Select bit of the running task (1 = ROM) |

## Verification
The hardest case to reach from the ports is a swap that is still waiting when another event arrives. The event can be a second swap, a completion strobe gap of several idle cycles, or a reset operation. The stimulus issues swaps on back-to-back completion strobes, with idle cycles between strobes, and directly before a reset operation. After each step it reads the emulator's bit through `task_id` = 0. The boot pattern cannot be seen directly. The bench makes it visible by issuing a reset operation and then reading every task's bit, after both accepted and rejected loads.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

  // Functions after qualification by completion strobe and task class
  typedef struct packed {
    logic load_boot;
    logic swap_req;
    logic step;
    logic reset_op;
  } tmc_cmd_t;

endpackage

// File: rtl/tmc_cmd_qual.sv
module tmc_cmd_qual
  import tmc_pkg::*;
(
  input  logic     task_is_ram,
  input  logic     fn_load_boot,
  input  logic     fn_swap,
  input  logic     uinst_done,
  input  logic     reset_op,
  output tmc_cmd_t cmd
);

  always_comb begin
    cmd           = '0;
    cmd.reset_op  = reset_op;
    cmd.step      = uinst_done & ~reset_op;
    cmd.load_boot = uinst_done & task_is_ram & fn_load_boot & ~reset_op;
    cmd.swap_req  = uinst_done & task_is_ram & fn_swap & ~reset_op;
  end

endmodule

// File: rtl/tmc_boot_reg.sv
module tmc_boot_reg
  import tmc_pkg::*;
#(
  parameter int NUM_TASKS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tmc_cmd_t             cmd,
  input  logic [NUM_TASKS-1:0] bus,
  output logic [NUM_TASKS-1:0] boot_q
);

  logic [NUM_TASKS-1:0] boot_d;
  logic                 boot_en;

  always_comb begin
    boot_en = cmd.reset_op | cmd.load_boot;
    boot_d  = boot_q;
    if (cmd.reset_op) begin
      boot_d = '1;
    end else if (cmd.load_boot) begin
      boot_d = bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= '1;
    end else if (boot_en) begin
      boot_q <= boot_d;
    end
  end

endmodule

// File: rtl/tmc_swap_delay.sv
module tmc_swap_delay
  import tmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tmc_cmd_t cmd,
  output logic     pend_q,
  output logic     flip_now
);

  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en  = cmd.reset_op | cmd.step;
    pend_d   = cmd.reset_op ? 1'b0 : cmd.swap_req;
    flip_now = pend_q & cmd.step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/tmc_mode_bank.sv
module tmc_mode_bank
  import tmc_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int EMU_TASK  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tmc_cmd_t             cmd,
  input  logic                 flip_now,
  input  logic [NUM_TASKS-1:0] boot_q,
  output logic [NUM_TASKS-1:0] mode_q
);

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    logic bit_d;
    logic bit_en;

    if (t == EMU_TASK) begin : g_emu
      always_comb begin
        bit_en = cmd.reset_op | flip_now;
        bit_d  = cmd.reset_op ? boot_q[t] : ~mode_q[t];
      end
    end else begin : g_other
      always_comb begin
        bit_en = cmd.reset_op;
        bit_d  = boot_q[t];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[t] <= 1'b1;
      end else if (bit_en) begin
        mode_q[t] <= bit_d;
      end
    end
  end

endmodule

// File: rtl/task_mode_ctl.sv
module task_mode_ctl
  import tmc_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int EMU_TASK  = 0,
  localparam int TASK_W   = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TASK_W-1:0]    task_id,
  input  logic                 task_is_ram,
  input  logic                 fn_load_boot,
  input  logic                 fn_swap,
  input  logic                 uinst_done,
  input  logic                 reset_op,
  input  logic [NUM_TASKS-1:0] bus,
  output logic                 cur_rom
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  tmc_cmd_t             cmd;
  logic [NUM_TASKS-1:0] boot_q;
  logic [NUM_TASKS-1:0] mode_q;
  logic                 pend_q;
  logic                 flip_now;

  tmc_cmd_qual u_qual (
    .task_is_ram  (task_is_ram),
    .fn_load_boot (fn_load_boot),
    .fn_swap      (fn_swap),
    .uinst_done   (uinst_done),
    .reset_op     (reset_op),
    .cmd          (cmd)
  );

  tmc_boot_reg #(.NUM_TASKS(NUM_TASKS)) u_boot (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cmd    (cmd),
    .bus    (bus),
    .boot_q (boot_q)
  );

  tmc_swap_delay u_delay (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .pend_q   (pend_q),
    .flip_now (flip_now)
  );

  tmc_mode_bank #(.NUM_TASKS(NUM_TASKS), .EMU_TASK(EMU_TASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .flip_now (flip_now),
    .boot_q   (boot_q),
    .mode_q   (mode_q)
  );

  assign cur_rom = mode_q[task_id];

endmodule

// File: rtl/task_mode_ctl_chk.sv
module task_mode_ctl_chk #(
  parameter int NUM_TASKS = 16,
  parameter int EMU_TASK  = 0
) (
  input logic                 clk,
  input logic                 rst_int_n,
  input logic                 task_is_ram,
  input logic                 fn_load_boot,
  input logic                 fn_swap,
  input logic                 uinst_done,
  input logic                 reset_op,
  input logic [NUM_TASKS-1:0] bus,
  input logic [NUM_TASKS-1:0] boot_q,
  input logic [NUM_TASKS-1:0] mode_q,
  input logic                 pend_q
);

  localparam logic [NUM_TASKS-1:0] EMU_MASK = NUM_TASKS'(1) << EMU_TASK;

  // R4, R5: reset operation copies the pattern, then the pattern returns to ones
  p_reset_copy_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    reset_op |=> (mode_q == $past(boot_q)) && (boot_q == '1) && !pend_q);

  // R3: qualified load takes the bus
  p_boot_load_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (uinst_done && fn_load_boot && task_is_ram && !reset_op) |=> boot_q == $past(bus));

  // R6: a waiting swap flips the emulator at the next completion strobe
  p_flip_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pend_q && uinst_done && !reset_op) |=> mode_q[EMU_TASK] != $past(mode_q[EMU_TASK]));

  // R6: a qualified swap leaves a pending flip
  p_swap_pending_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (uinst_done && fn_swap && task_is_ram && !reset_op) |=> pend_q);

  // R7: functions from a task that is not RAM-capable change nothing
  p_nonram_ignored_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (uinst_done && !task_is_ram && !pend_q && !reset_op)
      |=> !pend_q && $stable(mode_q) && $stable(boot_q));

  // R8: without a completion strobe no state moves
  p_no_step_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!uinst_done && !reset_op) |=> $stable(mode_q) && $stable(boot_q) && $stable(pend_q));

  // R9: outside a reset operation only the emulator bit may change
  p_others_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reset_op |=> ((mode_q ^ $past(mode_q)) & ~EMU_MASK) == '0);

endmodule

bind task_mode_ctl task_mode_ctl_chk #(.NUM_TASKS(NUM_TASKS), .EMU_TASK(EMU_TASK)) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .task_is_ram  (task_is_ram),
  .fn_load_boot (fn_load_boot),
  .fn_swap      (fn_swap),
  .uinst_done   (uinst_done),
  .reset_op     (reset_op),
  .bus          (bus),
  .boot_q       (boot_q),
  .mode_q       (mode_q),
  .pend_q       (pend_q)
);

// File: tb/test_task_mode_ctl.sv
`timescale 1ns/1ps
module test_task_mode_ctl;

  logic        clk;
  logic        rst_n;
  logic [3:0]  task_id;
  logic        task_is_ram;
  logic        fn_load_boot;
  logic        fn_swap;
  logic        uinst_done;
  logic        reset_op;
  logic [15:0] bus;
  logic        cur_rom;

  int checks;
  int failures;
  bit finished;

  typedef struct {
    int    tid;
    logic  exp;
    string tag;
  } item_t;

  item_t sb_q[$];

  // Reference state, updated from the requirements
  logic [15:0] exp_mode;
  logic [15:0] exp_boot;
  logic        exp_pend;

  task_mode_ctl i_task_mode_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_id      (task_id),
    .task_is_ram  (task_is_ram),
    .fn_load_boot (fn_load_boot),
    .fn_swap      (fn_swap),
    .uinst_done   (uinst_done),
    .reset_op     (reset_op),
    .bus          (bus),
    .cur_rom      (cur_rom)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Driver: one cycle of stimulus plus the reference update for that edge
  task automatic op(input logic ram, input logic ld, input logic sw,
                    input logic done, input logic rop, input logic [15:0] b);
    @(negedge clk);
    task_is_ram  = ram;
    fn_load_boot = ld;
    fn_swap      = sw;
    uinst_done   = done;
    reset_op     = rop;
    bus          = b;
    if (rop) begin
      exp_mode = exp_boot;
      exp_boot = '1;
      exp_pend = 1'b0;
    end else if (done) begin
      if (ram && ld) exp_boot = b;
      if (exp_pend) exp_mode[0] = ~exp_mode[0];
      exp_pend = ram && sw;
    end
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic check(input int tid, input string tag);
    item_t it;
    @(negedge clk);
    task_is_ram  = 1'b0;
    fn_load_boot = 1'b0;
    fn_swap      = 1'b0;
    uinst_done   = 1'b0;
    reset_op     = 1'b0;
    task_id      = tid[3:0];
    it.tid = tid;
    it.exp = exp_mode[tid];
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic check_all(input string tag);
    for (int t = 0; t < 16; t++) check(t, tag);
  endtask

  // Monitor: samples one time unit after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (cur_rom !== it.exp) begin
          failures++;
          $display("FAIL %s task=%0d actual=%b expected=%b", it.tag, it.tid, cur_rom, it.exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; finished = 0;
    task_id = 0; task_is_ram = 0; fn_load_boot = 0; fn_swap = 0;
    uinst_done = 0; reset_op = 0; bus = 0;
    exp_mode = '1; exp_boot = '1; exp_pend = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: every task on ROM after reset
    check_all("R2");

    // R3, R4: load a pattern, then a reset operation spreads it over the tasks
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h80F5);
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    check_all("R4");
    // R1: output follows task_id with no edge in between
    check(15, "R1");
    check(1, "R1");
    // R5: pattern back to ones after the reset operation
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    check_all("R5");

    // R8: load without the completion strobe
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    check_all("R8");
    // R7: load from a task that is not RAM-capable
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    check_all("R7");

    // R6: swap, emulator unchanged at the issuing strobe and across idle cycles
    op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    check(0, "R6");
    idle();
    idle();
    check(0, "R6");
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    check(0, "R6");
    // R9: other tasks untouched by the swap
    check_all("R9");

    // R7: swap from a task that is not RAM-capable
    op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    check(0, "R7");
    // R8: swap without the completion strobe
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    check(0, "R8");

    // R10: swaps at two consecutive strobes
    op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    check(0, "R10");
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    check(0, "R10");
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    check(0, "R10");

    // R10: reset operation drops a waiting swap
    op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    check(0, "R10");

    // R11: reset operation wins over a load in the same cycle
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'hAAAA);
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0000);
    check_all("R11");
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    check_all("R11");

    // R3, R6: emulator on RAM via the pattern, then a swap returns it to ROM
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h7FFE);
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    check(0, "R3");
    check(15, "R3");
    op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
    check(0, "R6");

    idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule